// File: doc/BRIEF.md
# Interrupt Request and Service Core

This block tracks interrupt requests for an eight-line interrupt controller. It catches one-cycle request pulses and drops those whose line is masked. Each pending line is held in a request register. The block raises an interrupt level toward the processor, or toward a master unit, while some pending line is not blocked by a line of equal or higher number that is already in service. Line 7 has the highest priority and line 0 the lowest.

On an acknowledge strobe the highest-numbered pending line is moved from the request register into the in-service register, and an 8-bit vector is returned. Lines whose cascade bit is set can hand the vector off to one attached slave controller. This uses a request/response handshake that is bounded by a timeout. An end-of-interrupt pulse that names a line clears that line's in-service bit, so lower lines waiting behind it are signalled again.

Top module: `irq_core`

## Requirements
- R1: A request pulse on a line whose `mask_cfg` bit is 1 is discarded, and that line's bit in `irr_out` stays 0.
- R2: A request pulse on an unmasked line sets that line's bit of `irr_out` after the next clock edge. Bit i of `irr_out` stands for line i.
- R3: `int_out` is 1 one cycle after a state in which some line i has its `irr_out` bit set and every `isr_out` bit from i up to 7 clear. It is 0 one cycle after a state in which no line meets this condition.
- R4: An accepted acknowledge picks the highest-numbered set bit of `irr_out`. After the next edge that bit is cleared and the same bit of `isr_out` is set.
- R5: For a line served locally, `vec_valid` is 1 in the cycle after the acknowledge, and `vec_out` = {`vec_base`[7:3], line number}. The low three bits of `vec_base` are ignored.
- R6: If the chosen line's `casc_cfg` bit is 1 and `slave_present` is 1, `slv_ack_req` rises after the acknowledge edge and stays high until `slv_vec_valid` is sampled. In the following cycle `vec_valid` is 1 and `vec_out` equals the `slv_vec` that was sampled.
- R7: If the cascade bit is 1 but `slave_present` is 0, the line is served locally as in R5.
- R8: An end-of-interrupt pulse clears the `isr_out` bit named by `eoi_line` at the next edge. A pending lower line that becomes unblocked drives `int_out` to 1 again.
- R9: An acknowledge while `irr_out` is 0 returns {`vec_base`[7:3], 3'b111} with `vec_valid`, and it leaves `irr_out` and `isr_out` unchanged.
- R10: If the slave does not answer within SLAVE_TIMEOUT waiting cycles, `slv_ack_req` falls and the spurious vector of R9 is returned.
- R11: `vec_valid` is high for exactly one cycle. An acknowledge strobe is ignored while a slave answer is awaited and in the cycle in which `vec_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pulse | input | 8 | One-cycle request pulses, one bit per line |
| mask_cfg | input | 8 | 1 = line masked |
| vec_base | input | 8 | Vector base; bits 2:0 ignored |
| casc_cfg | input | 8 | 1 = line has a slave behind it |
| slave_present | input | 1 | A slave controller is attached |
| ack_strobe | input | 1 | Interrupt acknowledge |
| eoi_pulse | input | 1 | End-of-interrupt for the line on eoi_line |
| eoi_line | input | 3 | Line number to retire |
| slv_vec | input | 8 | Vector returned by the slave |
| slv_vec_valid | input | 1 | Slave vector is valid |
| int_out | output | 1 | Interrupt level |
| vec_out | output | 8 | Acknowledge vector |
| vec_valid | output | 1 | vec_out valid, one cycle |
| slv_ack_req | output | 1 | Vector request to the slave |
| irr_out | output | 8 | Request register contents |
| isr_out | output | 8 | In-service register contents |

## Verification
The bench builds the core with eight lines, an 8-bit vector and SLAVE_TIMEOUT set to 6. This short timeout lets both the timed-out slave handshake and a slow slave reply that still arrives in time be reached within a few cycles. A behavioural model built from bit loops and integers predicts every output on every clock. Directed phases cover masking, nesting and blocking by priority, retirement, spurious acknowledges, cascading with and without a slave, and an acknowledge held over two cycles. A random phase then mixes all of these inputs.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [0:0] {ACK_IDLE = 1'b0, ACK_WAIT = 1'b1} ack_state_e;

  // index of the highest set bit; returns 0 for an empty vector
  function automatic logic [2:0] top_index8(input logic [7:0] v);
    logic [2:0] idx;
    idx = '0;
    for (int i = 0; i < 8; i++) begin
      if (v[i]) idx = 3'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/irq_request_reg.sv
module irq_request_reg #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] take_i,
  output logic [NUM_LINES-1:0] irr_q
);
  logic [NUM_LINES-1:0] accept_w;

  assign accept_w = req_i & ~mask_i;

  always_ff @(posedge clk) begin
    if (rst) irr_q <= '0;
    else     irr_q <= (irr_q & ~take_i) | accept_w;
  end

  // no bit may appear without an unmasked pulse in the previous cycle
  p_masked_drop_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irr_q & ~$past(irr_q) & ~$past(req_i & ~mask_i)) == '0));

  // a bit leaves only when the acknowledge logic takes it
  p_irr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(irr_q) & ~irr_q & ~$past(take_i)) == '0));
endmodule

// File: rtl/irq_service_reg.sv
module irq_service_reg #(
  parameter int NUM_LINES = 8,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irr_i,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic                 eoi_i,
  input  logic [LW-1:0]        eoi_line_i,
  output logic [NUM_LINES-1:0] isr_q,
  output logic                 int_q
);
  logic [NUM_LINES-1:0] eoi_clr_w;
  logic [NUM_LINES-1:0] pass_w;

  always_comb begin
    eoi_clr_w = '0;
    if (eoi_i) eoi_clr_w[eoi_line_i] = 1'b1;
  end

  // a line passes when pending and nothing at or above it is in service
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_gate
    assign pass_w[g] = irr_i[g] & ~(|isr_q[NUM_LINES-1:g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      int_q <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr_w) | set_i;
      int_q <= |pass_w;
    end
  end

  p_int_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    int_q |-> $past(irr_i != '0));

  p_isr_single_set_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(set_i) <= 1);

  p_eoi_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !set_i[eoi_line_i]) |=> !isr_q[$past(eoi_line_i)]);
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_LINES     = 8,
  parameter int VEC_W         = 8,
  parameter int SLAVE_TIMEOUT = 16,
  localparam int LW = $clog2(NUM_LINES),
  localparam int CW = $clog2(SLAVE_TIMEOUT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ack_i,
  input  logic [NUM_LINES-1:0] irr_i,
  input  logic [NUM_LINES-1:0] casc_i,
  input  logic                 slave_present_i,
  input  logic [VEC_W-1:0]     base_i,
  input  logic [VEC_W-1:0]     slv_vec_i,
  input  logic                 slv_vld_i,
  output logic [NUM_LINES-1:0] take_o,
  output logic [VEC_W-1:0]     vec_q,
  output logic                 vld_q,
  output logic                 slv_req_q
);
  ack_state_e     state_q;
  logic [CW-1:0]  wait_cnt_q;
  logic           accept_w;
  logic           empty_w;
  logic [LW-1:0]  pick_w;
  logic [VEC_W-1:0] spur_vec_w;
  logic [VEC_W-1:0] line_vec_w;

  assign empty_w    = (irr_i == '0);
  assign pick_w     = top_index8(irr_i);
  assign accept_w   = ack_i && (state_q == ACK_IDLE) && !vld_q;
  assign spur_vec_w = {base_i[VEC_W-1:LW], {LW{1'b1}}};
  assign line_vec_w = {base_i[VEC_W-1:LW], pick_w};

  always_comb begin
    take_o = '0;
    if (accept_w && !empty_w) take_o[pick_w] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ACK_IDLE;
      wait_cnt_q <= '0;
      vec_q      <= '0;
      vld_q      <= 1'b0;
      slv_req_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (state_q)
        ACK_IDLE: begin
          if (accept_w) begin
            if (empty_w) begin
              vec_q <= spur_vec_w;
              vld_q <= 1'b1;
            end else if (casc_i[pick_w] && slave_present_i) begin
              state_q    <= ACK_WAIT;
              slv_req_q  <= 1'b1;
              wait_cnt_q <= '0;
            end else begin
              vec_q <= line_vec_w;
              vld_q <= 1'b1;
            end
          end
        end
        ACK_WAIT: begin
          if (slv_vld_i) begin
            vec_q     <= slv_vec_i;
            vld_q     <= 1'b1;
            slv_req_q <= 1'b0;
            state_q   <= ACK_IDLE;
          end else if (wait_cnt_q == CW'(SLAVE_TIMEOUT - 1)) begin
            vec_q     <= spur_vec_w;
            vld_q     <= 1'b1;
            slv_req_q <= 1'b0;
            state_q   <= ACK_IDLE;
          end else begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
          end
        end
        default: state_q <= ACK_IDLE;
      endcase
    end
  end

  p_vld_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);

  p_wait_bound_r10: assert property (@(posedge clk) disable iff (rst)
    slv_req_q |-> (wait_cnt_q < CW'(SLAVE_TIMEOUT)));

  p_slv_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (slv_req_q && !slv_vld_i && (wait_cnt_q != CW'(SLAVE_TIMEOUT - 1))) |=> slv_req_q);

  p_take_pending_r4: assert property (@(posedge clk) disable iff (rst)
    ((take_o & ~irr_i) == '0));
endmodule

// File: rtl/irq_core.sv
module irq_core #(
  parameter int NUM_LINES     = 8,
  parameter int VEC_W         = 8,
  parameter int SLAVE_TIMEOUT = 16,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_pulse,
  input  logic [NUM_LINES-1:0] mask_cfg,
  input  logic [VEC_W-1:0]     vec_base,
  input  logic [NUM_LINES-1:0] casc_cfg,
  input  logic                 slave_present,
  input  logic                 ack_strobe,
  input  logic                 eoi_pulse,
  input  logic [LW-1:0]        eoi_line,
  input  logic [VEC_W-1:0]     slv_vec,
  input  logic                 slv_vec_valid,
  output logic                 int_out,
  output logic [VEC_W-1:0]     vec_out,
  output logic                 vec_valid,
  output logic                 slv_ack_req,
  output logic [NUM_LINES-1:0] irr_out,
  output logic [NUM_LINES-1:0] isr_out
);
  logic [NUM_LINES-1:0] take_w;

  irq_request_reg #(.NUM_LINES(NUM_LINES)) u_req (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_pulse),
    .mask_i (mask_cfg),
    .take_i (take_w),
    .irr_q  (irr_out)
  );

  irq_service_reg #(.NUM_LINES(NUM_LINES)) u_svc (
    .clk        (clk),
    .rst        (rst),
    .irr_i      (irr_out),
    .set_i      (take_w),
    .eoi_i      (eoi_pulse),
    .eoi_line_i (eoi_line),
    .isr_q      (isr_out),
    .int_q      (int_out)
  );

  irq_ack_ctrl #(
    .NUM_LINES     (NUM_LINES),
    .VEC_W         (VEC_W),
    .SLAVE_TIMEOUT (SLAVE_TIMEOUT)
  ) u_ack (
    .clk             (clk),
    .rst             (rst),
    .ack_i           (ack_strobe),
    .irr_i           (irr_out),
    .casc_i          (casc_cfg),
    .slave_present_i (slave_present),
    .base_i          (vec_base),
    .slv_vec_i       (slv_vec),
    .slv_vld_i       (slv_vec_valid),
    .take_o          (take_w),
    .vec_q           (vec_out),
    .vld_q           (vec_valid),
    .slv_req_q       (slv_ack_req)
  );

  p_spurious_nochange_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_strobe && !vec_valid && !slv_ack_req && (irr_out == '0) && !eoi_pulse)
      |=> (isr_out == $past(isr_out)));
endmodule

// File: tb/tb_irq_core.sv
module tb_irq_core;
  localparam int TO = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] req_pulse = '0, mask_cfg = '0, vec_base = 8'h43, casc_cfg = '0;
  logic slave_present = 1'b0, ack_strobe = 1'b0, eoi_pulse = 1'b0;
  logic [2:0] eoi_line = '0;
  logic [7:0] slv_vec = '0;
  logic slv_vec_valid = 1'b0;
  logic int_out, vec_valid, slv_ack_req;
  logic [7:0] vec_out, irr_out, isr_out;

  int n_checks = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  irq_core #(.NUM_LINES(8), .VEC_W(8), .SLAVE_TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .req_pulse(req_pulse), .mask_cfg(mask_cfg),
    .vec_base(vec_base), .casc_cfg(casc_cfg), .slave_present(slave_present),
    .ack_strobe(ack_strobe), .eoi_pulse(eoi_pulse), .eoi_line(eoi_line),
    .slv_vec(slv_vec), .slv_vec_valid(slv_vec_valid), .int_out(int_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .slv_ack_req(slv_ack_req),
    .irr_out(irr_out), .isr_out(isr_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_irr = 0, m_isr = 0, m_int = 0, m_vv = 0, m_vec = 0, m_sreq = 0, m_busy = 0, m_cnt = 0;

  function automatic int gate(input int irr, input int isr);
    for (int i = 0; i < 8; i++)
      if (irr[i] && ((isr >> i) == 0)) return 1;
    return 0;
  endfunction

  function automatic int top_line(input int v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  always @(posedge clk) begin
    int nint, nvv, ln, base_hi;
    cyc++;
    base_hi = int'(vec_base) & 'hF8;
    nint = gate(m_irr, m_isr);
    nvv = 0;
    if (rst) begin
      m_irr = 0; m_isr = 0; nint = 0; m_vec = 0; m_sreq = 0; m_busy = 0; m_cnt = 0;
    end else begin
      if (eoi_pulse) m_isr = m_isr & ~(1 << eoi_line);
      if (ack_strobe && !m_busy && !m_vv) begin
        if (m_irr == 0) begin
          nvv = 1; m_vec = base_hi | 7;
        end else begin
          ln = top_line(m_irr);
          m_irr = m_irr & ~(1 << ln);
          m_isr = m_isr | (1 << ln);
          if (casc_cfg[ln] && slave_present) begin
            m_busy = 1; m_sreq = 1; m_cnt = 0;
          end else begin
            nvv = 1; m_vec = base_hi | ln;
          end
        end
      end else if (m_busy) begin
        if (slv_vec_valid) begin
          nvv = 1; m_vec = int'(slv_vec); m_busy = 0; m_sreq = 0;
        end else if (m_cnt == TO - 1) begin
          nvv = 1; m_vec = base_hi | 7; m_busy = 0; m_sreq = 0;
        end else m_cnt++;
      end
      m_irr = m_irr | int'(req_pulse & ~mask_cfg);
    end
    m_int = nint;
    m_vv = nvv;
    #2;
    check("R2 irr", int'(irr_out), m_irr);
    check("R4 isr", int'(isr_out), m_isr);
    check("R3 int_out", int'(int_out), m_int);
    check("R11 vec_valid", int'(vec_valid), m_vv);
    check("R6 slv_ack_req", int'(slv_ack_req), m_sreq);
    if (m_vv) check("R5 vec_out", int'(vec_out), m_vec);
  end

  task automatic step(); @(negedge clk); endtask

  task automatic pulse_req(input logic [7:0] v);
    step(); req_pulse = v; step(); req_pulse = '0;
  endtask

  task automatic do_ack();
    step(); ack_strobe = 1'b1; step(); ack_strobe = 1'b0;
  endtask

  task automatic do_eoi(input int ln);
    step(); eoi_pulse = 1'b1; eoi_line = 3'(ln); step(); eoi_pulse = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R3 reset int", int'(int_out), 0);
    check("R2 reset irr", int'(irr_out), 0);
    check("R4 reset isr", int'(isr_out), 0);

    // R1 masked lines
    mask_cfg = 8'h0F;
    pulse_req(8'h05);
    check("R1 masked dropped", int'(irr_out), 0);
    step();
    check("R1 no int", int'(int_out), 0);
    mask_cfg = 8'h00;

    // R2/R3/R4/R5 nesting
    pulse_req(8'h28);
    check("R2 irr set", int'(irr_out), 'h28);
    step();
    check("R3 int high", int'(int_out), 1);
    do_ack();
    check("R5 vec line5", int'(vec_out), 'h45);
    check("R4 isr line5", int'(isr_out), 'h20);
    step();
    check("R3 line3 blocked", int'(int_out), 0);
    do_eoi(5);
    step();
    check("R8 int again", int'(int_out), 1);
    do_ack();
    check("R5 vec line3", int'(vec_out), 'h43);
    do_eoi(3);

    // R9 spurious
    do_ack();
    check("R9 spurious vec", int'(vec_out), 'h47);
    check("R9 isr unchanged", int'(isr_out), 0);

    // R6 cascade with slave
    casc_cfg = 8'h04; slave_present = 1'b1;
    pulse_req(8'h04);
    do_ack();
    check("R6 req raised", int'(slv_ack_req), 1);
    step(); step();
    slv_vec = 8'h9A; slv_vec_valid = 1'b1;
    step(); slv_vec_valid = 1'b0;
    check("R6 slave vec", int'(vec_out), 'h9A);
    check("R6 req dropped", int'(slv_ack_req), 0);
    do_eoi(2);

    // R7 cascade bit without slave
    slave_present = 1'b0;
    pulse_req(8'h04);
    do_ack();
    check("R7 local vec", int'(vec_out), 'h42);
    check("R7 no slave req", int'(slv_ack_req), 0);
    do_eoi(2);

    // R10 timeout
    slave_present = 1'b1;
    pulse_req(8'h04);
    do_ack();
    repeat (TO - 1) step();
    check("R10 still waiting", int'(slv_ack_req), 1);
    step();
    check("R10 timeout vec", int'(vec_out), 'h47);
    check("R10 valid", int'(vec_valid), 1);
    do_eoi(2);
    casc_cfg = 8'h00;

    // R11 held strobe accepted once
    pulse_req(8'h81);
    step(); ack_strobe = 1'b1; step(); step(); ack_strobe = 1'b0;
    check("R11 one accept irr", int'(irr_out), 'h01);
    check("R11 one accept isr", int'(isr_out), 'h80);
    do_eoi(7);

    // random mix
    casc_cfg = 8'h24;
    for (int k = 0; k < 1500; k++) begin
      step();
      req_pulse = 8'($urandom) & 8'($urandom);
      mask_cfg = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
      slave_present = 1'($urandom % 4 != 0);
      ack_strobe = 1'($urandom % 4 == 0);
      eoi_pulse = 1'($urandom % 3 == 0);
      eoi_line = 3'($urandom);
      vec_base = 8'($urandom);
      slv_vec = 8'($urandom);
      slv_vec_valid = slv_ack_req && ($urandom % 3 == 0);
    end
    step();
    req_pulse = '0; ack_strobe = 1'b0; eoi_pulse = 1'b0; slv_vec_valid = 1'b0;
    repeat (10) step();

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule